// File: doc/BRIEF.md
# Deferrable DRAM Refresh Scheduler

This block decides when a DRAM controller spends bus time on refresh. An interval timer adds one owed refresh to a small counter every nominal period. While refreshes are owed, the block raises a request to the main command scheduler. It starts the refresh sequence once two things are true: the scheduler grants the command bus, and the traffic side is not asking for a delay.

Refresh can be put off for a while. An age counter measures the time since the last refresh command. When that age reaches a hard ceiling, the sequence starts regardless of the defer and grant inputs. The sequence has four steps:
- one precharge-all command,
- a precharge wait,
- the refresh command,
- a recovery wait.

The busy flag stays high through all four steps, and the main scheduler must stall while it is high. If refreshes are still owed when recovery ends and no delay is requested, further refresh commands follow back to back. No new precharge is issued between them, because the banks are already closed.

Both intervals and both waits are clock-cycle counts given as parameters.

Top module: `refresh_sched`

## Requirements
- R1: While rst_ni is low, req_o and busy_o are 0 and cmd_o is NOP (2'b00).
- R2: One refresh becomes owed every NOMINAL_CYCLES clock cycles after reset. req_o goes high on the cycle after the counter first holds a non-zero value. With defaults overridden to NOMINAL_CYCLES=50, that is the 51st edge after reset release. req_o stays high until the sequence starts.
- R3: While defer_i is high and the deadline has not been reached, no precharge-all (2'b01) is issued, even when grant_i is high.
- R4: While grant_i is low and the deadline has not been reached, no precharge-all is issued, even when defer_i is low.
- R5: The age counts cycles since the last refresh command, or since reset. Once it reaches DEADLINE_CYCLES, a pending refresh issues precharge-all on the next edge, whatever defer_i and grant_i are doing. With DEADLINE_CYCLES=400 and a refresh owed, this happens on edge 401 after reset.
- R6: A refresh sequence opens with one precharge-all cycle. The refresh command (2'b10) follows exactly T_RP cycles after the precharge-all cycle.
- R7: After the refresh command cycle, busy_o stays high for exactly T_RFC further cycles of recovery.
- R8: At the end of recovery, if refreshes are still owed and defer_i is low (or the deadline has been reached), the next refresh command follows at once. Consecutive refresh commands are then 1+T_RFC cycles apart, with no precharge-all between them.
- R9: The owed count saturates at DEADLINE_CYCLES/NOMINAL_CYCLES+1. After a long deferral, a burst drains every saturated debt, so it holds at least that many refresh commands.
- R10: req_o and busy_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| defer_i | input | 1 | Traffic asks to put refresh off |
| grant_i | input | 1 | Main scheduler yields the command bus |
| req_o | output | 1 | Refresh owed and waiting for the bus |
| cmd_o | output | 2 | 00 NOP, 01 precharge all, 10 refresh |
| busy_o | output | 1 | Refresh sequence owns the bus; main scheduler stalls |

## Verification
Two functions can land in the same cycle:
- a new owed refresh coming from the interval timer, and
- a debt being retired by a refresh command.

They are provoked together during long deferrals and back-to-back bursts, where ticks fall on refresh cycles and on a saturated counter. The outcome is judged by the length of the burst and the spacing of its commands.

The deadline force is tested separately. It is driven with defer held high and grant held low, and the bench checks the exact edge of the precharge-all. A behavioural per-cycle model is compared against req_o, busy_o and cmd_o on every cycle.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PENDING, ST_PRECHARGE_ALL, ST_REFRESH, ST_RECOVER
  } rf_state_e;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_PREA = 2'b01,
    CMD_REF  = 2'b10
  } rf_cmd_e;
endpackage

// File: rtl/refresh_interval.sv
module refresh_interval #(
  parameter int NOMINAL_CYCLES = 1600,
  parameter int OWED_MAX       = 9,
  parameter int OWED_W         = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dec_i,
  output logic [OWED_W-1:0] owed_o,
  output logic              owed_nz_o
);
  localparam int NOM_W = $clog2(NOMINAL_CYCLES);

  logic [NOM_W-1:0]  cnt_q;
  logic [OWED_W-1:0] owed_q;
  logic              tick;

  assign tick = (cnt_q == NOM_W'(NOMINAL_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owed_q <= '0;
    else if (tick && !dec_i && owed_q != OWED_W'(OWED_MAX)) owed_q <= owed_q + 1'b1;
    else if (dec_i && !tick && owed_q != '0) owed_q <= owed_q - 1'b1;
  end

  assign owed_o    = owed_q;
  assign owed_nz_o = (owed_q != '0);

  // R9
  owed_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owed_q <= OWED_W'(OWED_MAX));

  // R2
  owed_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owed_q != OWED_W'(OWED_MAX)) |=> (owed_q <= $past(owed_q) + 1'b1));
endmodule

// File: rtl/refresh_age.sv
module refresh_age #(
  parameter int DEADLINE_CYCLES = 14000,
  parameter int AGE_W           = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic due_o
);
  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (clear_i) age_q <= '0;
    else if (age_q != AGE_W'(DEADLINE_CYCLES)) age_q <= age_q + 1'b1;
  end

  assign due_o = (age_q == AGE_W'(DEADLINE_CYCLES));

  // R5
  due_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !due_o);

  // R5
  due_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (due_o && !clear_i) |=> due_o);
endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
  import refresh_pkg::*;
#(
  parameter int T_RP   = 4,
  parameter int T_RFC  = 26,
  parameter int WAIT_W = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       owed_nz_i,
  input  logic       due_i,
  input  logic       defer_i,
  input  logic       grant_i,
  output logic       req_o,
  output logic       busy_o,
  output logic [1:0] cmd_o,
  output logic       ref_o
);
  rf_state_e         state_q, state_d;
  logic [WAIT_W-1:0] wcnt_q, wcnt_d;
  logic              rp_done, rfc_done;

  assign rp_done  = (wcnt_q == WAIT_W'(T_RP - 1));
  assign rfc_done = (wcnt_q == WAIT_W'(T_RFC - 1));

  always_comb begin
    state_d = state_q;
    wcnt_d  = wcnt_q;
    unique case (state_q)
      ST_IDLE: if (owed_nz_i) state_d = ST_PENDING;
      ST_PENDING: begin
        if (due_i || (grant_i && !defer_i)) begin
          state_d = ST_PRECHARGE_ALL;
          wcnt_d  = '0;
        end
      end
      ST_PRECHARGE_ALL: begin
        if (rp_done) begin
          state_d = ST_REFRESH;
          wcnt_d  = '0;
        end else wcnt_d = wcnt_q + 1'b1;
      end
      ST_REFRESH: begin
        state_d = ST_RECOVER;
        wcnt_d  = '0;
      end
      ST_RECOVER: begin
        if (rfc_done) begin
          wcnt_d = '0;
          // banks are still closed: chain further refreshes without precharge
          if (owed_nz_i && (!defer_i || due_i)) state_d = ST_REFRESH;
          else if (owed_nz_i)                   state_d = ST_PENDING;
          else                                  state_d = ST_IDLE;
        end else wcnt_d = wcnt_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
    end
  end

  assign req_o  = (state_q == ST_PENDING);
  assign busy_o = (state_q == ST_PRECHARGE_ALL) || (state_q == ST_REFRESH) ||
                  (state_q == ST_RECOVER);
  assign ref_o  = (state_q == ST_REFRESH);

  always_comb begin
    cmd_o = CMD_NOP;
    if (state_q == ST_PRECHARGE_ALL && wcnt_q == '0) cmd_o = CMD_PREA;
    else if (state_q == ST_REFRESH)                  cmd_o = CMD_REF;
  end

  // R10
  req_busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_o && busy_o));

  // R5
  deadline_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && due_i) |=> (cmd_o == CMD_PREA));

  // R3
  defer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && defer_i && !due_i) |=> req_o);

  // R6
  ref_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF) |-> $past(busy_o));
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int NOMINAL_CYCLES  = 1600,
  parameter int DEADLINE_CYCLES = 14000,
  parameter int T_RP            = 4,
  parameter int T_RFC           = 26
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       defer_i,
  input  logic       grant_i,
  output logic       req_o,
  output logic [1:0] cmd_o,
  output logic       busy_o
);
  localparam int OWED_MAX = DEADLINE_CYCLES / NOMINAL_CYCLES + 1;
  localparam int OWED_W   = $clog2(OWED_MAX + 1);
  localparam int AGE_W    = $clog2(DEADLINE_CYCLES + 1);
  localparam int WAIT_MAX = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

  logic [OWED_W-1:0] owed;
  logic              owed_nz, due, ref_issue;

  refresh_interval #(
    .NOMINAL_CYCLES(NOMINAL_CYCLES), .OWED_MAX(OWED_MAX), .OWED_W(OWED_W)
  ) u_interval (
    .clk_i(clk_i), .rst_ni(rst_ni), .dec_i(ref_issue),
    .owed_o(owed), .owed_nz_o(owed_nz)
  );

  refresh_age #(
    .DEADLINE_CYCLES(DEADLINE_CYCLES), .AGE_W(AGE_W)
  ) u_age (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(ref_issue), .due_o(due)
  );

  refresh_seq #(
    .T_RP(T_RP), .T_RFC(T_RFC), .WAIT_W(WAIT_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .owed_nz_i(owed_nz), .due_i(due),
    .defer_i(defer_i), .grant_i(grant_i), .req_o(req_o), .busy_o(busy_o),
    .cmd_o(cmd_o), .ref_o(ref_issue)
  );

  // R9
  burst_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF && owed != '0) |=> (owed <= $past(owed)));
endmodule

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;
  localparam int NOM = 50, DL = 400, TRP = 3, TRFC = 6;
  localparam int OMAX = DL / NOM + 1;

  logic clk = 1'b0, rst_n = 1'b0, defer = 1'b0, grant = 1'b0;
  logic req, busy;
  logic [1:0] cmd;
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  refresh_sched #(.NOMINAL_CYCLES(NOM), .DEADLINE_CYCLES(DL), .T_RP(TRP), .T_RFC(TRFC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .defer_i(defer), .grant_i(grant),
    .req_o(req), .cmd_o(cmd), .busy_o(busy));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // behavioural model: phase 0 idle, 1 waiting, 2 precharge, 3 refresh, 4 recovery
  int m_tick = 0, m_owed = 0, m_age = 0, m_ph = 0, m_w = 0, m_refs = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_tick = 0; m_owed = 0; m_age = 0; m_ph = 0; m_w = 0;
    end else begin
      automatic bit tk = (m_tick == NOM - 1);
      automatic bit due = (m_age == DL);
      automatic int ph = m_ph;
      automatic int w = m_w;
      automatic int o = m_owed;
      cyc++;
      m_tick = tk ? 0 : m_tick + 1;
      m_owed = o + (tk ? 1 : 0) - (ph == 3 ? 1 : 0);
      if (m_owed > OMAX) m_owed = OMAX;
      m_age = (ph == 3) ? 0 : ((m_age < DL) ? m_age + 1 : DL);
      case (ph)
        0: if (o > 0) m_ph = 1;
        1: if (due || (grant && !defer)) begin m_ph = 2; m_w = 0; end
        2: if (w == TRP - 1) begin m_ph = 3; m_w = 0; end else m_w = w + 1;
        3: begin m_ph = 4; m_w = 0; end
        default: if (w == TRFC - 1) begin
          m_w = 0;
          m_ph = (o > 0 && (!defer || due)) ? 3 : (o > 0) ? 1 : 0;
        end else m_w = w + 1;
      endcase
    end
  end

  always @(negedge clk) if (rst_n) begin
    automatic int ecmd = (m_ph == 2 && m_w == 0) ? 1 : (m_ph == 3) ? 2 : 0;
    check(req == (m_ph == 1), "R2 req_o vs model", int'(req), int'(m_ph == 1));
    check(busy == (m_ph >= 2), "R7 busy_o vs model", int'(busy), int'(m_ph >= 2));
    check(int'(cmd) == ecmd, "R6 cmd_o vs model", int'(cmd), ecmd);
    check(!(req && busy), "R10 exclusive", int'(req && busy), 0);
    if (ecmd == 2) m_refs++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_up();
  end

  initial begin
    int first_req, prea_c, ref_c, k, prev, n, mref0;
    bit bad;
    defer = 1'b1; grant = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check(!req && !busy && cmd == 2'b00, "R1 reset outputs", {req, busy, cmd}, 0);
    rst_n = 1'b1;
    first_req = -1;
    do begin
      @(negedge clk);
      if (req && first_req < 0) first_req = cyc;
    end while (cmd != 2'b01);
    prea_c = cyc;
    check(first_req == 51, "R2 first request edge", first_req, 51);
    check(prea_c == 401, "R5 forced precharge edge", prea_c, 401);
    do @(negedge clk); while (cmd != 2'b10);
    ref_c = cyc;
    check(ref_c - prea_c == TRP, "R6 precharge to refresh", ref_c - prea_c, TRP);
    k = 0;
    @(negedge clk);
    while (busy) begin k++; @(negedge clk); end
    check(k == TRFC, "R7 recovery length", k, TRFC);
    check(req == 1'b1, "R2 debt still pending", int'(req), 1);

    grant = 1'b1; bad = 0;
    repeat (100) begin @(negedge clk); if (cmd == 2'b01) bad = 1; end
    check(!bad, "R3 defer blocks precharge", int'(bad), 0);

    defer = 1'b0; grant = 1'b0; bad = 0;
    repeat (50) begin @(negedge clk); if (cmd == 2'b01) bad = 1; end
    check(!bad, "R4 no grant blocks precharge", int'(bad), 0);

    grant = 1'b1;
    @(negedge clk);
    check(cmd == 2'b01, "R4 grant starts sequence", int'(cmd), 1);
    prev = -1; bad = 0; n = 0;
    @(negedge clk);
    while (busy) begin
      if (cmd == 2'b01) bad = 1;
      if (cmd == 2'b10) begin
        if (prev >= 0 && cyc - prev != TRFC + 1) bad = 1;
        prev = cyc; n++;
      end
      @(negedge clk);
    end
    check(!bad && n > 1, "R8 back-to-back spacing", n, OMAX);

    grant = 1'b0; defer = 1'b1;
    repeat (3000) @(negedge clk);
    while (busy) @(negedge clk);
    defer = 1'b0; grant = 1'b1;
    mref0 = m_refs; n = 0;
    do begin @(negedge clk); if (cmd == 2'b10) n++; end while (busy || req);
    check(n >= OMAX, "R9 saturated burst length", n, OMAX);
    check(n == m_refs - mref0, "R9 burst matches model", n, m_refs - mref0);
    finish_up();
  end
endmodule